// File: doc/BRIEF.md
# Colour-Tagged Sample Packetizer with Serial Transmitter

This block collects 12-bit light-intensity samples, each tagged with the LED colour it was taken under. The samples wait in a small first-in first-out store until a host asks for them. A single request strobe starts a drain. The drain sends every sample held at that moment, oldest first, over an asynchronous serial transmit line.

Each sample goes out as three serial bytes. The first is a header whose value names the colour. The next two carry the sample: first the upper four bits, padded with zeros, then the lower eight bits. Status outputs show whether the store is empty, full or has lost data, and whether a drain is in progress.

The bit period is a parameter given in clock cycles. With 868 cycles, a 100 MHz clock gives about 115,200 bit/s.

Top module: `sample_uart_packer`

## Requirements
- R1: After reset, `tx` is 1, `buf_empty` is 1, and `buf_full`, `overflow` and `busy` are 0.
- R2: The first byte of each packet is a colour header. Colour code 0 (red) sends 0xA1, code 1 (green) sends 0xA2 and code 2 (blue) sends 0xA3.
- R3: The second byte of a packet is {4'b0000, sample[11:8]} and the third is sample[7:0].
- R4: Every byte is one frame: a start bit of 0, eight data bits with the least significant bit first, then a stop bit of 1, with no parity. While nothing is being sent, `tx` stays at 1.
- R5: Every bit holds on `tx` for exactly `BIT_CYCLES` clock cycles.
- R6: Accepted samples are stored and are not sent until a request arrives. Until then `tx` stays high and `busy` stays low.
- R7: A request taken while idle sends exactly the samples stored in that cycle, in arrival order. Samples that arrive during the drain stay stored for a later request.
- R8: A request that arrives while `busy` is 1 is ignored. It neither lengthens the drain nor clears `overflow`.
- R9: The store holds `DEPTH` samples (64 by default). A valid sample that arrives while the store is full is dropped and sets `overflow`. `overflow` stays set until a request is taken while idle.
- R10: A sample with colour code 3 is ignored. It is neither stored nor sent, and it does not set `overflow`.
- R11: `buf_empty` is 1 exactly when no sample is stored, and `buf_full` is 1 exactly when `DEPTH` samples are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe, one cycle per sample |
| in_color | input | 2 | Colour code: 0 red, 1 green, 2 blue, 3 invalid |
| in_sample | input | 12 | Sample value |
| req | input | 1 | Host request strobe that starts a drain |
| tx | output | 1 | Serial transmit line, high when idle |
| buf_empty | output | 1 | Store holds no samples |
| buf_full | output | 1 | Store holds DEPTH samples |
| overflow | output | 1 | Sticky flag: a sample was lost to a full store |
| busy | output | 1 | A drain is in progress |

## Verification
A wrong read pointer or a wrong drain counter shows up at the line within one packet time. It appears as a header or data byte that differs from the oldest expected sample, or as a packet too many or too few before `busy` falls. A baud counter that is off by one cycle moves each mid-bit sample point further along. By the last data bits the drift is several cycles, so the sampled bits and the stop bit come out wrong in the first frame. An occupancy counter that slips shows in `buf_full`, `buf_empty` and `overflow` in the cycle after the write. It also shows in the length of the next drain.

// File: rtl/sample_uart_packer.sv
module sample_uart_packer #(
  parameter int DEPTH      = 64,
  parameter int BIT_CYCLES = 868
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [1:0]  in_color,
  input  logic [11:0] in_sample,
  input  logic        req,
  output logic        tx,
  output logic        buf_empty,
  output logic        buf_full,
  output logic        overflow,
  output logic        busy
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam int BW = $clog2(BIT_CYCLES);

  logic [13:0]   mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count, drain_left;
  logic          tx_active;
  logic [1:0]    byte_idx;
  logic [3:0]    bit_idx;
  logic [BW-1:0] baud;
  logic [9:0]    shreg;
  logic [15:0]   tail;

  wire        good_col = in_valid && (in_color != 2'd3);
  wire        full_now = (count == CW'(DEPTH));
  wire        push     = good_col && !full_now;
  wire        drop     = good_col && full_now;
  wire        accept   = req && !busy;
  wire        pop      = !tx_active && (drain_left != '0);
  wire        bit_end  = tx_active && (baud == BW'(BIT_CYCLES - 1));
  wire [13:0] head     = mem[rd_ptr];
  wire [7:0]  hdr      = 8'hA1 + {6'b0, head[13:12]};

  assign busy      = tx_active || (drain_left != '0);
  assign buf_empty = (count == '0);
  assign buf_full  = full_now;
  assign tx        = tx_active ? shreg[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= {in_color, in_sample};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      count      <= '0;
      drain_left <= '0;
      overflow   <= 1'b0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      count <= count + CW'(push) - CW'(pop);
      if (accept)   drain_left <= count;
      else if (pop) drain_left <= drain_left - 1'b1;
      if (drop)        overflow <= 1'b1;
      else if (accept) overflow <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_active <= 1'b0;
      byte_idx  <= '0;
      bit_idx   <= '0;
      baud      <= '0;
      shreg     <= '1;
      tail      <= '0;
    end else if (pop) begin
      tx_active <= 1'b1;
      byte_idx  <= '0;
      bit_idx   <= '0;
      baud      <= '0;
      shreg     <= {1'b1, hdr, 1'b0};
      tail      <= {4'b0000, head[11:8], head[7:0]};
    end else if (tx_active) begin
      if (!bit_end) begin
        baud <= baud + 1'b1;
      end else begin
        baud <= '0;
        if (bit_idx != 4'd9) begin
          bit_idx <= bit_idx + 1'b1;
          shreg   <= {1'b1, shreg[9:1]};
        end else begin
          bit_idx <= '0;
          if (byte_idx == 2'd2) begin
            tx_active <= 1'b0;
          end else begin
            byte_idx <= byte_idx + 1'b1;
            shreg    <= {1'b1, tail[15:8], 1'b0};
            tail     <= {tail[7:0], 8'h00};
          end
        end
      end
    end
  end

  AST_LINE_IDLE_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx) |-> busy); // R4
  AST_COUNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R9
  AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !(req && !busy)) |=> overflow); // R9
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(buf_empty && buf_full)); // R11
  AST_REQ_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req) |=> (drain_left <= $past(drain_left))); // R8
  AST_INVALID_COLOUR_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_color == 2'd3 && !tx_active && drain_left == '0) |=> $stable(count)); // R10
endmodule

// File: tb/sample_uart_packer_test.sv
module sample_uart_packer_test;
  localparam int DEPTH = 64;
  localparam int BITC  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [1:0] in_color = '0;
  logic [11:0] in_sample = '0;
  logic req = 1'b0;
  logic tx, buf_empty, buf_full, overflow, busy;

  int checks = 0;
  int errors = 0;
  logic [13:0] q[$];
  bit ovf_m = 1'b0;

  always #5 clk = ~clk;

  sample_uart_packer #(.DEPTH(DEPTH), .BIT_CYCLES(BITC)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_color(in_color),
    .in_sample(in_sample), .req(req), .tx(tx), .buf_empty(buf_empty),
    .buf_full(buf_full), .overflow(overflow), .busy(busy));

  function automatic logic [7:0] exp_byte(logic [13:0] s, int idx);
    if (idx == 0) return 8'hA1 + {6'b0, s[13:12]};
    if (idx == 1) return {4'b0000, s[11:8]};
    return s[7:0];
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic push(logic [1:0] c, logic [11:0] v);
    @(negedge clk);
    in_valid = 1'b1; in_color = c; in_sample = v;
    @(negedge clk);
    in_valid = 1'b0;
    if (c != 2'd3) begin
      if (q.size() < DEPTH) q.push_back({c, v});
      else ovf_m = 1'b1;
    end
  endtask

  task automatic quiet(int n, string tag);
    int lows = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!tx || busy) lows++;
    end
    chk(tag, lows, 0);
  endtask

  task automatic recv_byte(output logic [7:0] b);
    int w = 0;
    b = '0;
    while (tx && w < 2000) begin
      @(negedge clk);
      w++;
    end
    chk("R4 start bit seen", int'(tx), 0);
    repeat (BITC / 2) @(negedge clk);
    chk("R5 start bit mid", int'(tx), 0);
    for (int i = 0; i < 8; i++) begin
      repeat (BITC) @(negedge clk);
      b[i] = tx;
    end
    repeat (BITC) @(negedge clk);
    chk("R4 stop bit", int'(tx), 1);
  endtask

  task automatic drain(int extra, bit extra_req);
    int n;
    logic [7:0] b;
    logic [13:0] s;
    @(negedge clk);
    req = 1'b1;
    n = q.size();
    ovf_m = 1'b0;
    @(negedge clk);
    req = 1'b0;
    for (int k = 0; k < n; k++) begin
      s = q.pop_front();
      for (int j = 0; j < 3; j++) begin
        recv_byte(b);
        chk(j == 0 ? "R2 header" : "R3 data byte", int'(b), int'(exp_byte(s, j)));
        if (j == 2 && extra_req && k == 0) begin
          @(negedge clk);
          req = 1'b1;
          @(negedge clk);
          req = 1'b0;
        end else if (j == 2 && extra > 0) begin
          push(2'($urandom_range(0, 2)), 12'($urandom));
          extra--;
        end
      end
    end
    for (int w = 0; w < 100 && busy; w++) @(negedge clk);
    chk("R7 drain length ends", int'(busy), 0);
    quiet(3 * BITC, "R8 no extra packets after drain");
    chk("R11 empty flag", int'(buf_empty), int'(q.size() == 0));
    chk("R9 overflow after request", int'(overflow), int'(ovf_m));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 tx idle", int'(tx), 1);
    chk("R1 empty", int'(buf_empty), 1);
    chk("R1 full", int'(buf_full), 0);
    chk("R1 overflow", int'(overflow), 0);
    chk("R1 busy", int'(busy), 0);

    push(2'd0, 12'h000);
    push(2'd1, 12'hFFF);
    push(2'd2, 12'h5A3);
    push(2'd0, 12'h801);
    chk("R11 not empty", int'(buf_empty), 0);
    quiet(200, "R6 held until request");
    drain(0, 1'b0);

    push(2'd3, 12'h123);
    chk("R10 colour 3 not stored", int'(buf_empty), 1);
    chk("R10 colour 3 no overflow", int'(overflow), 0);
    @(negedge clk); req = 1'b1; @(negedge clk); req = 1'b0;
    quiet(100, "R10 nothing sent");

    for (int r = 0; r < 6; r++) begin
      int n = $urandom_range(1, 10);
      for (int i = 0; i < n; i++) push(2'($urandom_range(0, 3)), 12'($urandom));
      drain($urandom_range(0, 3), r[0]);
    end
    while (q.size() > 0) drain(0, 1'b0);

    for (int i = 0; i < DEPTH; i++) push(2'($urandom_range(0, 2)), 12'($urandom));
    chk("R11 full flag", int'(buf_full), 1);
    chk("R9 no overflow at exactly full", int'(overflow), 0);
    push(2'd1, 12'hABC);
    push(2'd2, 12'h111);
    chk("R9 overflow set", int'(overflow), 1);
    chk("R9 still full", int'(buf_full), 1);
    repeat (5) @(negedge clk);
    chk("R9 overflow sticky", int'(overflow), 1);
    drain(0, 1'b1);
    chk("R11 not full after drain", int'(buf_full), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule